// File: doc/BRIEF.md
# Dual-Channel Read-Only Memory Sequencer with Width Adaptation

This block sits between an on-chip read port and two banks of external read-only memory. Each bank has a select line of its own. A bank is built either 32 bits wide or 16 bits wide. The block accepts one read request at a time, together with its byte enables, and turns it into one or two external bus cycles. It drives the bank select, output enable, bus-start strobe and address. When a bank is only 16 bits wide, it puts the half-words back together into a 32-bit result. The number of output-enable clocks in each cycle comes from a per-bank wait field.

Bank 0 takes its width from a strap pin that is sampled while reset is held, so a system can boot from either kind of part. The width of bank 1 and the wait fields of both banks come from a small configuration write port. A request can be marked as coming from an external bus master. In that case the block first idles for one clock with every strobe and its address driver inactive, which gives the master time to release the shared address lines. The master's own request address is the one presented to the memory.

Top module: `romseq_top`

## Requirements
- R1: While reset is low, the bank 0 width flag follows `boot_half` (1 = 16-bit). Writes to bank 0 through the configuration port never change that flag.
- R2: After reset, both wait fields read as 15 and bank 1 is 32-bit. A write with `cfg_we` high sets the wait field of bank `cfg_ch` to `cfg_wait`, and for bank 1 it also sets the width flag to `cfg_half`.
- R3: On a 16-bit bank, a request with at least one enable in bytes 0-1 and at least one in bytes 2-3 makes two bus cycles. The first uses address bit 1 = 0 and the second uses bit 1 = 1. A single done pulse follows the second cycle.
- R4: On a 16-bit bank, a request whose enables lie only in bytes 0-1, or only in bytes 2-3, makes exactly one bus cycle, with address bit 1 = 0 or 1 respectively.
- R5: On a 32-bit bank every request makes exactly one bus cycle, with address bits 1:0 driven as zero.
- R6: Each bus cycle is one clock with `mem_bstart_n` low, the bank select low and `mem_oe_n` high, then wait+1 clocks with select and `mem_oe_n` low. `mem_swe_n` stays high. `rsp_done` is seen 1 + E + N*(wait+2) clocks after the accepting edge (E = 1 for an external-master request, N = bus cycles).
- R7: For an external-master request, the first clock after acceptance has `mem_addr_oe` low, all selects high, `mem_oe_n` high and `mem_bstart_n` high.
- R8: In `rsp_data`, byte k is zero when enable k is low. From a 16-bit bank, the half-word read at bit 1 = 0 fills bits 15:0 and the one read at bit 1 = 1 fills bits 31:16. Only `mem_rdata[15:0]` is used.
- R9: `busy` goes high at acceptance and low one clock after the single-clock `rsp_done` pulse. At reset, `busy`, `rsp_done` and all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_half | input | 1 | Strap: bank 0 is 16-bit when high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Bank addressed by the write |
| cfg_wait | input | WW | Wait field value |
| cfg_half | input | 1 | Width flag value (bank 1 only) |
| req_valid | input | 1 | Read request, taken when not busy |
| req_ch | input | CHW | Target bank |
| req_addr | input | AW | Byte address |
| req_be | input | 4 | Byte enables |
| req_ext | input | 1 | Request from an external bus master |
| busy | output | 1 | Request in progress |
| rsp_done | output | 1 | Result valid pulse |
| rsp_data | output | 32 | Assembled read data |
| mem_addr | output | AW | External address |
| mem_addr_oe | output | 1 | Address driver enable |
| mem_ce_n | output | NCH | Bank selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_swe_n | output | 1 | Write enable, held high |
| mem_bstart_n | output | 1 | Bus-cycle start strobe, active low |
| mem_rdata | input | 32 | Data from the memory |

## Verification
The bench builds the block with AW = 12, NCH = 2 and WW = 4. With those values the full 0..15 wait range can be swept on both banks, and every width and byte-enable combination is reached within a few hundred requests. Midway through, the block is reset a second time with the strap inverted, so bank 0 is tested at both widths. The memory models drive junk on the upper data pins of 16-bit banks, so any use of unused lanes shows up in the result.

// File: rtl/romseq_pkg.sv
package romseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GAP    = 3'd1,
    ST_START  = 3'd2,
    ST_STROBE = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_t;

  localparam int unsigned BYTES = 4;
  localparam int unsigned DW    = 8 * BYTES;
endpackage

// File: rtl/romseq_cfg.sv
module romseq_cfg #(
  parameter int unsigned NCH = 2,
  parameter int unsigned WW  = 4,
  parameter int unsigned CHW = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rst_sn,
  input  logic                    boot_half,
  input  logic                    cfg_we,
  input  logic [CHW-1:0]          cfg_ch,
  input  logic [WW-1:0]           cfg_wait,
  input  logic                    cfg_half,
  output logic [NCH-1:0][WW-1:0]  wait_vec,
  output logic [NCH-1:0]          half_vec
);
  localparam logic [WW-1:0] WAIT_RST = '1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_en;
    assign wr_en = cfg_we && (cfg_ch == CHW'(c));

    logic [WW-1:0] wait_q, wait_d;
    always_comb begin
      wait_d = wait_q;
      if (wr_en) wait_d = cfg_wait;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= WAIT_RST;
      else        wait_q <= wait_d;
    end
    assign wait_vec[c] = wait_q;

    if (c == 0) begin : g_strap
      logic half_q;
      always_ff @(posedge clk) begin
        if (!rst_sn) half_q <= boot_half;
      end
      assign half_vec[c] = half_q;

      a_r1_strap_hold: assert property (@(posedge clk) disable iff (!rst_sn)
        cfg_we && (cfg_ch == CHW'(0)) |=> $stable(half_q));
    end else begin : g_soft
      logic half_q, half_d;
      always_comb begin
        half_d = half_q;
        if (wr_en) half_d = cfg_half;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_d;
      end
      assign half_vec[c] = half_q;
    end
  end
endmodule

// File: rtl/romseq_ctrl.sv
module romseq_ctrl
  import romseq_pkg::*;
#(
  parameter int unsigned AW  = 24,
  parameter int unsigned NCH = 2,
  parameter int unsigned WW  = 4,
  parameter int unsigned CHW = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [CHW-1:0]         req_ch,
  input  logic [AW-1:0]          req_addr,
  input  logic [BYTES-1:0]       req_be,
  input  logic                   req_ext,
  input  logic [NCH-1:0][WW-1:0] wait_vec,
  input  logic [NCH-1:0]         half_vec,
  output logic                   busy,
  output logic                   start,
  output logic                   cap_en,
  output logic                   cap_upper,
  output logic                   lat_half,
  output logic [BYTES-1:0]       lat_be,
  output logic                   done,
  output logic [AW-1:0]          mem_addr,
  output logic                   mem_addr_oe,
  output logic [NCH-1:0]         mem_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_swe_n,
  output logic                   mem_bstart_n
);
  seq_state_t st_q, st_d;
  logic [WW-1:0]    cnt_q, cnt_d, wait_q;
  logic [AW-1:0]    addr_q;
  logic [BYTES-1:0] be_q;
  logic [CHW-1:0]   ch_q;
  logic             half_q, ext_q, split_q, upper_q, upper_d;
  logic             lo_any, hi_any, sel_half, last_clk;

  assign lo_any   = |req_be[1:0];
  assign hi_any   = |req_be[3:2];
  assign sel_half = half_vec[req_ch];
  assign start    = (st_q == ST_IDLE) && req_valid;
  assign last_clk = (st_q == ST_STROBE) && (cnt_q == wait_q);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    upper_d = upper_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d    = req_ext ? ST_GAP : ST_START;
          upper_d = sel_half && !lo_any;
        end
      end
      ST_GAP:   st_d = ST_START;
      ST_START: begin
        st_d  = ST_STROBE;
        cnt_d = '0;
      end
      ST_STROBE: begin
        if (cnt_q == wait_q) begin
          if (split_q && !upper_q) begin
            st_d    = ST_START;
            upper_d = 1'b1;
          end else begin
            st_d = ST_DONE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      upper_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      upper_q <= upper_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      ch_q    <= '0;
      wait_q  <= '0;
      half_q  <= 1'b0;
      ext_q   <= 1'b0;
      split_q <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      be_q    <= req_be;
      ch_q    <= req_ch;
      wait_q  <= wait_vec[req_ch];
      half_q  <= sel_half;
      ext_q   <= req_ext;
      split_q <= sel_half && lo_any && hi_any;
    end
  end

  logic on_bus;
  assign on_bus       = (st_q == ST_START) || (st_q == ST_STROBE);
  assign busy         = (st_q != ST_IDLE);
  assign done         = (st_q == ST_DONE);
  assign cap_en       = last_clk;
  assign cap_upper    = upper_q;
  assign lat_half     = half_q;
  assign lat_be       = be_q;
  assign mem_addr_oe  = on_bus;
  assign mem_addr     = !on_bus ? '0 :
                        half_q  ? {addr_q[AW-1:2], upper_q, 1'b0} :
                                  {addr_q[AW-1:2], 2'b00};
  assign mem_oe_n     = !(st_q == ST_STROBE);
  assign mem_bstart_n = !(st_q == ST_START);
  assign mem_swe_n    = 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_ce
    assign mem_ce_n[c] = !(on_bus && (ch_q == CHW'(c)));
  end

  a_r6_oe_needs_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> $onehot(~mem_ce_n));
  a_r6_ce_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));
  a_r6_start_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_bstart_n));
  a_r7_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && ext_q |-> (!mem_addr_oe && mem_oe_n && mem_bstart_n && (&mem_ce_n)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r3_second_half_upper: assert property (@(posedge clk) disable iff (!rst_n)
    done && split_q |-> cap_upper);
endmodule

// File: rtl/romseq_pack.sv
module romseq_pack
  import romseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cap_en,
  input  logic             cap_upper,
  input  logic             lat_half,
  input  logic [BYTES-1:0] lat_be,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             done,
  output logic [DW-1:0]    rsp_data
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] buf_q, buf_d, mask;

  always_comb begin
    buf_d = buf_q;
    if (start) begin
      buf_d = '0;
    end else if (cap_en) begin
      if (!lat_half)      buf_d = mem_rdata;
      else if (cap_upper) buf_d[DW-1:HW] = mem_rdata[HW-1:0];
      else                buf_d[HW-1:0]  = mem_rdata[HW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign mask[8*b +: 8] = {8{lat_be[b]}};
  end

  assign rsp_data = buf_q & mask;

  a_r8_capture_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cap_en));
endmodule

// File: rtl/romseq_top.sv
module romseq_top
  import romseq_pkg::*;
#(
  parameter int unsigned AW  = 24,
  parameter int unsigned NCH = 2,
  parameter int unsigned WW  = 4,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boot_half,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [WW-1:0]   cfg_wait,
  input  logic            cfg_half,
  input  logic            req_valid,
  input  logic [CHW-1:0]  req_ch,
  input  logic [AW-1:0]   req_addr,
  input  logic [3:0]      req_be,
  input  logic            req_ext,
  output logic            busy,
  output logic            rsp_done,
  output logic [31:0]     rsp_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_addr_oe,
  output logic [NCH-1:0]  mem_ce_n,
  output logic            mem_oe_n,
  output logic            mem_swe_n,
  output logic            mem_bstart_n,
  input  logic [31:0]     mem_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [NCH-1:0][WW-1:0] wait_vec;
  logic [NCH-1:0]         half_vec;
  logic                   start, cap_en, cap_upper, lat_half;
  logic [BYTES-1:0]       lat_be;

  romseq_cfg #(.NCH(NCH), .WW(WW), .CHW(CHW)) i_cfg (
    .clk(clk), .rst_n(rst_sn), .rst_sn(rst_sn), .boot_half(boot_half),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wait(cfg_wait), .cfg_half(cfg_half),
    .wait_vec(wait_vec), .half_vec(half_vec)
  );

  romseq_ctrl #(.AW(AW), .NCH(NCH), .WW(WW), .CHW(CHW)) i_ctrl (
    .clk(clk), .rst_n(rst_sn),
    .req_valid(req_valid), .req_ch(req_ch), .req_addr(req_addr),
    .req_be(req_be), .req_ext(req_ext),
    .wait_vec(wait_vec), .half_vec(half_vec),
    .busy(busy), .start(start), .cap_en(cap_en), .cap_upper(cap_upper),
    .lat_half(lat_half), .lat_be(lat_be), .done(rsp_done),
    .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_swe_n(mem_swe_n), .mem_bstart_n(mem_bstart_n)
  );

  romseq_pack i_pack (
    .clk(clk), .rst_n(rst_sn), .start(start), .cap_en(cap_en),
    .cap_upper(cap_upper), .lat_half(lat_half), .lat_be(lat_be),
    .mem_rdata(mem_rdata), .done(rsp_done), .rsp_data(rsp_data)
  );
endmodule

// File: tb/test_romseq_top.sv
module test_romseq_top;
  localparam int CLK_P = 10;
  localparam int AW    = 12;
  localparam int NCH   = 2;
  localparam int WW    = 4;

  logic clk = 1'b0;
  logic rst_n, boot_half, cfg_we, cfg_half, req_valid, req_ext;
  logic [0:0] cfg_ch, req_ch;
  logic [WW-1:0] cfg_wait;
  logic [AW-1:0] req_addr, mem_addr;
  logic [3:0] req_be;
  logic busy, rsp_done, mem_addr_oe, mem_oe_n, mem_swe_n, mem_bstart_n;
  logic [31:0] rsp_data, mem_rdata;
  logic [NCH-1:0] mem_ce_n;

  int checks = 0, errors = 0, cycles = 0;
  int tb_wait [NCH];
  bit tb_half [NCH];

  always #(CLK_P/2) clk = ~clk;

  romseq_top #(.AW(AW), .NCH(NCH), .WW(WW)) i_romseq_top (
    .clk(clk), .rst_n(rst_n), .boot_half(boot_half), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_wait(cfg_wait), .cfg_half(cfg_half),
    .req_valid(req_valid), .req_ch(req_ch), .req_addr(req_addr),
    .req_be(req_be), .req_ext(req_ext), .busy(busy), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_swe_n(mem_swe_n),
    .mem_bstart_n(mem_bstart_n), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] f16(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[7:0], a[15:8]};
  endfunction
  function automatic logic [31:0] f32(input logic [31:0] a);
    return {a[15:0] ^ 16'h1234, ~a[15:0] ^ 16'h00F0};
  endfunction

  always_comb begin
    mem_rdata = 32'hF0F0_0F0F;
    for (int c = 0; c < NCH; c++)
      if (!mem_ce_n[c] && !mem_oe_n)
        mem_rdata = tb_half[c] ? {16'hDEAD, f16(32'(mem_addr))} : f32(32'(mem_addr));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 1'b0; boot_half = strap; cfg_we = 0; req_valid = 0;
    cfg_ch = 0; cfg_wait = 0; cfg_half = 0; req_ch = 0; req_addr = 0;
    req_be = 0; req_ext = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tb_half[0] = strap; tb_half[1] = 0; tb_wait[0] = 15; tb_wait[1] = 15;
    // R9: idle state after reset
    chk(!busy && !rsp_done, "R9", "busy/done after reset", {busy, rsp_done}, 0);
    chk(&mem_ce_n && mem_oe_n && mem_bstart_n && mem_swe_n, "R9",
        "strobes after reset", {mem_ce_n, mem_oe_n, mem_bstart_n, mem_swe_n}, 5'h1F);
  endtask

  task automatic cfg_write(input int ch, input int w, input bit h);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 1'(ch); cfg_wait = WW'(w); cfg_half = h;
    @(negedge clk);
    cfg_we = 0;
    tb_wait[ch] = w;
    if (ch != 0) tb_half[ch] = h; // R1: bank 0 width is strap only
  endtask

  task automatic access(input int ch, input logic [AW-1:0] a,
                        input logic [3:0] be, input bit ext);
    bit half = tb_half[ch];
    bit lo = |be[1:0], hi = |be[3:2];
    int n = (half && lo && hi) ? 2 : 1;
    int w = tb_wait[ch];
    int lat = 1 + int'(ext) + n * (w + 2);
    logic [31:0] exp, mask;
    logic [31:0] base = 32'({a[AW-1:2], 2'b00});
    int k = 0, nbs = 0, noe = 0;
    logic [1:0] a1s = 0;
    bit seen = 0, bad_ce = 0, bad_swe = 0;
    for (int b = 0; b < 4; b++) mask[8*b +: 8] = {8{be[b]}};
    if (half) exp = {f16(base | 32'h2), f16(base)} & mask;
    else      exp = f32(base) & mask;
    @(negedge clk);
    req_valid = 1; req_ch = 1'(ch); req_addr = a; req_be = be; req_ext = ext;
    while (!seen && k < 200) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (k == 1) begin
        req_valid = 0;
        if (ext)
          chk(!mem_addr_oe && &mem_ce_n && mem_oe_n && mem_bstart_n, "R7",
              "quiet gap clock", {mem_addr_oe, mem_ce_n, mem_oe_n, mem_bstart_n}, 5'h0F);
        else
          chk(!mem_bstart_n, "R6", "bus start right after accept", mem_bstart_n, 0);
      end
      if (!mem_bstart_n) begin
        if (nbs < 2) a1s[nbs] = mem_addr[1];
        nbs++;
        if (!half) chk(mem_addr[1:0] == 0, "R5", "aligned address", mem_addr[1:0], 0);
      end
      if (!mem_oe_n) noe++;
      if ((!mem_bstart_n || !mem_oe_n) && mem_ce_n != ~(NCH'(1) << ch)) bad_ce = 1;
      if (!mem_swe_n) bad_swe = 1;
      if (rsp_done) seen = 1;
    end
    chk(k == lat, "R6", "done latency", k, lat);
    chk(noe == n * (w + 1), "R6", "output-enable clocks", noe, n * (w + 1));
    chk(!bad_ce && !bad_swe, "R6", "select/write strobes", {bad_ce, bad_swe}, 0);
    if (half && n == 2) begin
      chk(nbs == 2, "R3", "two bus cycles", nbs, 2);
      chk(a1s == 2'b10, "R3", "lower half first", a1s, 2'b10);
    end else if (half) begin
      chk(nbs == 1, "R4", "one bus cycle", nbs, 1);
      chk(a1s[0] == !lo, "R4", "lane address bit", a1s[0], !lo);
    end else begin
      chk(nbs == 1, "R5", "one bus cycle", nbs, 1);
    end
    chk(rsp_data == exp, "R8", "result data", rsp_data, exp);
    chk(busy, "R9", "busy with done", busy, 1);
    @(negedge clk);
    chk(!busy && !rsp_done, "R9", "done single clock", {busy, rsp_done}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset(1'b1);
    // R1/R2: reset wait 15, bank 0 16-bit from strap, bank 1 32-bit
    access(0, 12'h124, 4'hF, 0);
    access(1, 12'h340, 4'hF, 0);
    // R1: write to bank 0 keeps width
    cfg_write(0, 2, 1'b0);
    access(0, 12'h208, 4'hF, 0);
    // R2: bank 1 becomes 16-bit, wait 0
    cfg_write(1, 0, 1'b1);
    access(1, 12'h010, 4'hF, 0);
    // R4/R8 lanes
    access(1, 12'h014, 4'h1, 0);
    access(1, 12'h014, 4'h8, 0);
    access(1, 12'h018, 4'h3, 0);
    access(1, 12'h018, 4'hC, 0);
    // R3 three-byte
    access(0, 12'h01C, 4'h7, 0);
    access(0, 12'h01C, 4'hE, 0);
    // R7 external master
    access(0, 12'h3F0, 4'hF, 1);
    access(1, 12'h3F4, 4'h2, 1);
    cfg_write(1, 15, 1'b0);
    access(1, 12'hFFC, 4'hF, 1);
    for (int i = 0; i < 60; i++) begin
      if (i % 8 == 0) cfg_write(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                                1'($urandom_range(0, 1)));
      access(int'($urandom_range(0, 1)), AW'($urandom), 4'($urandom_range(1, 15)),
             1'($urandom_range(0, 1)));
    end
    // R1: second reset with strap low makes bank 0 32-bit
    do_reset(1'b0);
    access(0, 12'h100, 4'hF, 0);
    access(0, 12'h104, 4'h6, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule